// File: doc/BRIEF.md
# Polled Priority Interrupt Controller

An eight-level interrupt controller that a host services entirely by register access. Each request line feeds a request register. The controller keeps an in-service register for the levels the host has taken, and a mask register that hides levels from arbitration. A fixed-priority resolver picks the winning level. Level 0 ranks highest, and a level wins only when it is unmasked and no in-service bit of equal or higher rank is set. The interrupt output is raised while such a winner exists.

The host talks to the block through a byte-wide port with two addresses: a command address and a data address. A poll command tells the next command-address read to return a found flag and the winning level. That read also serves as the acknowledge: it moves the winning bit from the request register into the in-service register. End-of-interrupt commands retire in-service bits. Outside a poll, the command address shows either the request register or the in-service register, depending on a sticky select.

Read data is combinational in the cycle `rd_i` is high. The side effects of a read or write take place at the next rising clock edge.

Top module: `poll_irq_ctrl`

## Requirements
- R1: After reset, the request, in-service and mask registers are all zero, `int_o` is low, a command-address read returns the request register, and no poll is armed.
- R2: When `level_mode_i` is 0, a rising edge on `irq_i[n]` sets request bit n. A line that stays high does not set the bit again after an acknowledge. If the line drops before the acknowledge, the bit clears.
- R3: When `level_mode_i` is 1, request bit n follows `irq_i[n]`. It reappears after an acknowledge while the line is still high, and it clears when the line goes low.
- R4: A masked level never drives `int_o` and is never chosen by a poll. Its request bit is kept, so the level fires once it is unmasked.
- R5: Priority is fixed with level 0 highest. A set in-service bit blocks its own level and every lower-ranked level.
- R6: Writing 0x0C to the command address (`port_sel_i`=0) arms a poll. The next command-address read returns bit 7 = 1, bits 6:3 = 0 and bits 2:0 = the winning level. That read disarms the poll.
- R7: A poll read with no resolvable request returns 0x00 and leaves the in-service register unchanged.
- R8: A successful poll read clears the winning request bit and sets the matching in-service bit at the next clock edge.
- R9: Writing 0x60 | n to the command address clears in-service bit n only.
- R10: Writing 0x20 to the command address clears the highest-priority in-service bit that is set.
- R11: Command 0x0B makes non-poll command-address reads return the in-service register, and command 0x0A makes them return the request register. The selection persists across reads and across polls.
- R12: A write to the data address (`port_sel_i`=1) loads the mask register, with bit n masking level n. A data-address read returns the mask.
- R13: `int_o` is high exactly when a resolvable request exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| level_mode_i | input | 1 | 1: level-sensitive requests, 0: rising-edge requests |
| irq_i | input | 8 | Request lines, bit n is level n |
| port_sel_i | input | 1 | 0: command address, 1: data address |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while `rd_i` is high |
| int_o | output | 1 | Interrupt pending |

## Verification
Two functions can fall in the same clock edge: the poll-read acknowledge of one level, and a new rising edge on a higher-priority line. The bench provokes this by raising `irq_i[1]` in the same cycle as the poll read that takes level 6. The read must still report level 6, because the result comes from the registered request state. The new request must be latched rather than lost, so the following poll returns level 1 even though level 6 is then in service.

// File: rtl/poll_irq_pkg.sv
package poll_irq_pkg;
  localparam int unsigned NUM_LVL = 8;
  localparam int unsigned LVL_W   = $clog2(NUM_LVL);

  localparam logic [7:0] CMD_POLL     = 8'h0C;
  localparam logic [7:0] CMD_SEL_IRR  = 8'h0A;
  localparam logic [7:0] CMD_SEL_ISR  = 8'h0B;
  localparam logic [7:0] CMD_NS_EOI   = 8'h20;
  localparam logic [7:0] CMD_SP_EOI   = 8'h60;
  localparam logic [7:0] SP_EOI_MASK  = 8'hF8;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         level_mode_i,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] ack_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] irq_q, irr_q, set_vec;

  assign set_vec = level_mode_i ? irq_i : (irq_i & ~irq_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= '0;
      irr_q <= '0;
    end else begin
      irq_q <= irq_i;
      irr_q <= (irr_q | set_vec) & irq_i & ~ack_i;
    end
  end

  assign irr_o = irr_q;

  // R8
  ack_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_i));

  // R4 masking never drops a held request
  irr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(irr_q & irq_i & ~ack_i) & ~irr_q) == '0));
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
  parameter int unsigned N     = 8,
  parameter int unsigned LVL_W = $clog2(N)
) (
  input  logic [N-1:0]     irr_i,
  input  logic [N-1:0]     isr_i,
  input  logic [N-1:0]     mask_i,
  output logic             found_o,
  output logic [LVL_W-1:0] lvl_o
);
  always_comb begin
    logic stop;
    stop    = 1'b0;
    found_o = 1'b0;
    lvl_o   = '0;
    for (int i = 0; i < N; i++) begin
      if (!stop) begin
        if (isr_i[i]) begin
          stop = 1'b1;
        end else if (irr_i[i] && !mask_i[i]) begin
          found_o = 1'b1;
          lvl_o   = LVL_W'(i);
          stop    = 1'b1;
        end
      end
    end
  end

  // R4 R5
  always_comb begin
    if (found_o) begin
      win_valid_chk: assert (irr_i[lvl_o] && !mask_i[lvl_o] && !isr_i[lvl_o]);
    end
  end
endmodule

// File: rtl/irq_service_reg.sv
module irq_service_reg #(
  parameter int unsigned N     = 8,
  parameter int unsigned LVL_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     ack_i,
  input  logic             eoi_spec_i,
  input  logic             eoi_ns_i,
  input  logic [LVL_W-1:0] eoi_lvl_i,
  output logic [N-1:0]     isr_o
);
  logic [N-1:0] isr_q, ns_clr, sp_clr, clr_vec;

  always_comb begin
    logic hit;
    hit    = 1'b0;
    ns_clr = '0;
    for (int i = 0; i < N; i++) begin
      if (!hit && isr_q[i]) begin
        ns_clr[i] = 1'b1;
        hit       = 1'b1;
      end
    end
  end

  assign sp_clr  = N'(1) << eoi_lvl_i;
  assign clr_vec = (eoi_ns_i ? ns_clr : '0) | (eoi_spec_i ? sp_clr : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= (isr_q | ack_i) & ~clr_vec;
  end

  assign isr_o = isr_q;

  // R8
  ack_sets_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i != '0 && !eoi_spec_i && !eoi_ns_i) |=> ((isr_q & $past(ack_i)) == $past(ack_i)));

  // R9
  sp_eoi_exact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_spec_i && ack_i == '0) |=> (isr_q == ($past(isr_q) & ~$past(sp_clr))));

  // R10
  ns_eoi_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_ns_i && ack_i == '0 && isr_q != '0) |=>
      ($countones($past(isr_q)) == $countones(isr_q) + 1));
endmodule

// File: rtl/poll_irq_ctrl.sv
module poll_irq_ctrl
  import poll_irq_pkg::*;
#(
  parameter int unsigned N = NUM_LVL
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         level_mode_i,
  input  logic [N-1:0] irq_i,
  input  logic         port_sel_i,
  input  logic         wr_i,
  input  logic         rd_i,
  input  logic [7:0]   wdata_i,
  output logic [7:0]   rdata_o,
  output logic         int_o
);
  localparam int unsigned LW  = $clog2(N);
  localparam int unsigned PAD = 7 - LW;

  logic [N-1:0]  irr, isr, mask_q, ack_vec;
  logic          found, poll_q, sel_isr_q;
  logic [LW-1:0] win_lvl;
  logic          cmd_wr, cmd_rd, data_wr, poll_rd, eoi_spec, eoi_ns;
  logic [7:0]    poll_byte, stat_byte;

  assign cmd_wr   = wr_i & ~port_sel_i;
  assign data_wr  = wr_i &  port_sel_i;
  assign cmd_rd   = rd_i & ~port_sel_i;
  assign poll_rd  = cmd_rd & poll_q;
  assign eoi_spec = cmd_wr && ((wdata_i & SP_EOI_MASK) == CMD_SP_EOI);
  assign eoi_ns   = cmd_wr && (wdata_i == CMD_NS_EOI);
  assign ack_vec  = (poll_rd && found) ? (N'(1) << win_lvl) : '0;

  irq_req_latch #(.N(N)) i_req (
    .clk_i, .rst_ni, .level_mode_i, .irq_i,
    .ack_i (ack_vec),
    .irr_o (irr)
  );

  irq_prio_resolver #(.N(N), .LVL_W(LW)) i_res (
    .irr_i   (irr),
    .isr_i   (isr),
    .mask_i  (mask_q),
    .found_o (found),
    .lvl_o   (win_lvl)
  );

  irq_service_reg #(.N(N), .LVL_W(LW)) i_svc (
    .clk_i, .rst_ni,
    .ack_i      (ack_vec),
    .eoi_spec_i (eoi_spec),
    .eoi_ns_i   (eoi_ns),
    .eoi_lvl_i  (wdata_i[LW-1:0]),
    .isr_o      (isr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      poll_q    <= 1'b0;
      sel_isr_q <= 1'b0;
      mask_q    <= '0;
    end else begin
      if (data_wr) mask_q <= wdata_i[N-1:0];
      if (cmd_wr && wdata_i == CMD_POLL)         poll_q <= 1'b1;
      else if (cmd_rd)                           poll_q <= 1'b0;
      if (cmd_wr && wdata_i == CMD_SEL_ISR)      sel_isr_q <= 1'b1;
      else if (cmd_wr && wdata_i == CMD_SEL_IRR) sel_isr_q <= 1'b0;
    end
  end

  assign poll_byte = {found, {PAD{1'b0}}, win_lvl};
  assign stat_byte = 8'(sel_isr_q ? isr : irr);

  always_comb begin
    if (!rd_i)          rdata_o = '0;
    else if (port_sel_i) rdata_o = 8'(mask_q);
    else if (poll_q)     rdata_o = poll_byte;
    else                 rdata_o = stat_byte;
  end

  assign int_o = found;

  // R7
  spurious_no_svc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_rd && !found && !wr_i) |=> $stable(isr));

  // R6
  poll_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_rd && !cmd_wr) |=> !poll_q);

  // R11
  sel_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_wr |=> $stable(sel_isr_q));

  // R13
  int_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> ((irr & ~mask_q) != '0));
endmodule

// File: tb/test_poll_irq_ctrl.sv
module test_poll_irq_ctrl;
  logic       clk_i = 0, rst_ni = 0, level_mode_i = 0;
  logic [7:0] irq_i = '0;
  logic       port_sel_i = 0, wr_i = 0, rd_i = 0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic       int_o;

  int total = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk_i = ~clk_i;

  poll_irq_ctrl i_poll_irq_ctrl (.*);

  task automatic check(logic [7:0] act, logic [7:0] exp, string req);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compares every read against the scoreboard
  always @(negedge clk_i) begin
    #3;
    if (rd_i) begin
      if (exp_q.size() == 0) check(rdata_o, 8'hxx, "unexpected read");
      else check(rdata_o, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr(logic sel, logic [7:0] d);
    @(negedge clk_i); port_sel_i = sel; wdata_i = d; wr_i = 1;
    @(negedge clk_i); wr_i = 0;
  endtask

  task automatic rd(logic sel, logic [7:0] exp, string req, logic [7:0] extra = '0);
    @(negedge clk_i);
    exp_q.push_back(exp); tag_q.push_back(req);
    port_sel_i = sel; rd_i = 1; irq_i = irq_i | extra;
    @(negedge clk_i); rd_i = 0;
  endtask

  task automatic set_irq(logic [7:0] v);
    @(negedge clk_i); irq_i = v;
  endtask

  task automatic int_chk(logic exp, string req);
    @(negedge clk_i); #1 check({7'b0, int_o}, {7'b0, exp}, req);
  endtask

  task automatic rd_irr(logic [7:0] exp, string req);
    wr(0, 8'h0A); rd(0, exp, req);
  endtask

  task automatic rd_isr(logic [7:0] exp, string req);
    wr(0, 8'h0B); rd(0, exp, req);
  endtask

  task automatic poll(logic [7:0] exp, string req, logic [7:0] extra = '0);
    wr(0, 8'h0C); rd(0, exp, req, extra);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    int_chk(0, "R1 int low");
    rd(0, 8'h00, "R1 status is IRR");
    rd(1, 8'h00, "R1 mask zero");
    rd_isr(8'h00, "R1 ISR zero");
    wr(0, 8'h0A);
    // R12 mask port
    wr(1, 8'hA5);
    rd(1, 8'hA5, "R12 mask readback");
    wr(1, 8'h00);
    // R2 edge, R6 R8 R13
    set_irq(8'h20);
    int_chk(1, "R13 int on pending");
    rd(0, 8'h20, "R2 edge sets IRR");
    poll(8'h85, "R6 poll returns level 5");
    rd(0, 8'h00, "R8 IRR cleared, R2 no re-set");
    rd_isr(8'h20, "R8 ISR set");
    rd(0, 8'h20, "R11 ISR select persists");
    int_chk(0, "R13 int low");
    // R5 priority blocking
    set_irq(8'hA0);
    int_chk(0, "R5 lower level blocked by ISR");
    set_irq(8'hA4);
    int_chk(1, "R5 higher level passes");
    poll(8'h82, "R5 poll picks level 2");
    rd(0, 8'h24, "R11 ISR after poll");
    wr(0, 8'h62);
    rd_isr(8'h20, "R9 specific EOI level 2");
    wr(0, 8'h20);
    rd(0, 8'h00, "R10 non-specific EOI");
    int_chk(1, "R5 level 7 now resolvable");
    poll(8'h87, "R6 poll level 7");
    wr(0, 8'h20);
    // R7 spurious
    set_irq(8'h00);
    rd_irr(8'h00, "R7 IRR empty");
    poll(8'h00, "R7 spurious result");
    rd_isr(8'h00, "R7 ISR unchanged");
    wr(0, 8'h0A);
    // R4 masking
    wr(1, 8'h08);
    set_irq(8'h08);
    int_chk(0, "R4 masked no int");
    rd(0, 8'h08, "R4 IRR kept while masked");
    poll(8'h00, "R4 masked not polled");
    wr(1, 8'h00);
    int_chk(1, "R4 fires on unmask");
    poll(8'h83, "R4 poll level 3");
    wr(0, 8'h63);
    set_irq(8'h00);
    // R2 drop before ack
    set_irq(8'h02);
    rd_irr(8'h02, "R2 latched");
    set_irq(8'h00);
    rd(0, 8'h00, "R2 cleared on drop");
    // R3 level mode
    level_mode_i = 1;
    set_irq(8'h10);
    rd(0, 8'h10, "R3 follows line");
    poll(8'h84, "R3 poll level 4");
    rd(0, 8'h10, "R3 reappears after ack");
    rd_isr(8'h10, "R3 ISR set");
    wr(0, 8'h64);
    int_chk(1, "R3 int after EOI");
    set_irq(8'h00);
    int_chk(0, "R3 line low clears");
    level_mode_i = 0;
    wr(0, 8'h0A);
    // same-cycle ack and new higher request
    set_irq(8'h40);
    poll(8'h86, "R8 collision read old winner", 8'h02);
    rd_irr(8'h02, "R2 new edge latched at ack");
    poll(8'h81, "R5 higher level preempts");
    rd_isr(8'h42, "R8 both in service");
    wr(0, 8'h20);
    wr(0, 8'h20);
    rd(0, 8'h00, "R10 all retired");
    repeat (3) @(negedge clk_i);
    finish_run();
  end
endmodule